// File: doc/BRIEF.md
# Load/Store Address Generator

This block turns a single-register load or store instruction into the address sent to memory and the new value of the base register. It takes the instruction word, the base register value, the index register value, the instruction's own address and the current carry flag. Both offset forms are handled: a 12-bit immediate, or an index register shifted by an immediate amount. Each can be used in three addressing modes: plain offset, pre-indexed with base update, and post-indexed. The block also reports the access size, the direction and whether the access must be performed with user-mode permissions.

Results are registered. An instruction presented with `valid_in` high in one cycle appears on the outputs after the next rising clock edge, with `valid_out` high. The output stage has two states. It is EMPTY after reset or when no instruction was offered, and HOLDING when a result is present. EMPTY goes to HOLDING on an offered instruction. HOLDING goes to EMPTY when none is offered. Reset returns it to EMPTY from either state. Internally, each instruction is sorted into one of three addressing kinds: OFFSET, PRE or POST. That choice decides the address and the base update.

Top module: `lsag_unit`

## Requirements
- R1: The outputs `is_load` and `is_byte` equal instruction bits 20 and 22. All results appear one clock edge after `valid_in`, marked by `valid_out`. A cycle without `valid_in` gives `valid_out` low after the next edge.
- R2: With bit 25 clear, the offset is bits [11:0] zero-extended. Bit 23 set adds the offset to the base, and clear subtracts it. `base_new` always carries base plus or minus offset.
- R3: With bit 24 clear (POST), `addr_out` is the unmodified base, `base_new` is base plus or minus offset, and write-back is requested whatever bit 21 says.
- R4: With bit 24 set and bit 21 set (PRE), `addr_out` and `base_new` are both base plus or minus offset, and write-back is requested.
- R5: With bit 24 set and bit 21 clear (OFFSET), `addr_out` is base plus or minus offset and `base_wb` stays low.
- R6: `force_user` is high exactly when bit 24 is clear and bit 21 is set.
- R7: With bit 25 set, the offset is the index register shifted by the amount in bits [11:7]. The shift kind comes from bits [6:5]: 0 is shift left, 1 is logical right, 2 is arithmetic right, 3 is rotate right. An amount of 0 means 32 for the two right shifts. For rotate, an amount of 0 means a one-bit rotate through carry, with the carry entering bit 31. Bit 23 selects add or subtract in every mode.
- R8: With bit 25 set and bit 4 set, `undef_out` is high and `base_wb` is low.
- R9: A base field (bits [19:16]) of 15 reads as `pc_val` + 8, and `base_wb` is then low.
- R10: For a load whose destination field (bits [15:12]) equals the base field, `base_wb` is low, so the loaded value wins. A store with the same fields still writes back.
- R11: While `rst` is high, `valid_out` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Instruction presented this cycle |
| instr_in | input | 32 | Instruction word |
| rn_val | input | 32 | Base register value |
| rm_val | input | 32 | Index register value |
| pc_val | input | 32 | Address of the instruction |
| carry_in | input | 1 | Current carry flag |
| valid_out | output | 1 | Results valid |
| addr_out | output | 32 | Memory address |
| base_new | output | 32 | Updated base value |
| base_wb | output | 1 | Write `base_new` to the base register |
| wb_reg | output | 4 | Base register number |
| is_byte | output | 1 | Byte access |
| is_load | output | 1 | Load (else store) |
| force_user | output | 1 | Perform access with user permissions |
| undef_out | output | 1 | Register-specified shift, not supported |

## Verification
A post-indexed access with bit 21 set does two things in the same cycle: it raises `force_user`, and it requests base write-back. The bench drives such an instruction, and separately one whose load destination equals its base. It then judges `force_user`, `base_wb`, `addr_out` and `base_new` together on the result cycle. The write-back suppressors are also combined with other functions in one cycle: a base of 15 in PRE mode, and a register-specified shift in PRE mode. Each of these must drop the write-back while the address arithmetic still comes out exact.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
    localparam int XLEN = 32;
    localparam int IMM_W = 12;
    localparam int SHAMT_W = 5;
    localparam int REG_IDX_W = 4;
    localparam int PC_AHEAD = 8;

    typedef enum logic [1:0] {
        MODE_OFFSET = 2'd0,
        MODE_PRE    = 2'd1,
        MODE_POST   = 2'd2
    } idx_mode_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    typedef struct packed {
        idx_mode_e                mode;
        logic                     reg_form;
        logic                     add;
        logic                     byte_acc;
        logic                     load;
        logic                     user_acc;
        logic                     bad_shift;
        logic [REG_IDX_W-1:0]     base_idx;
        logic [REG_IDX_W-1:0]     dest_idx;
        logic [IMM_W-1:0]         imm;
        logic [SHAMT_W-1:0]       shamt;
        shift_kind_e              kind;
    } ls_fields_t;
endpackage

// File: rtl/lsag_decode.sv
module lsag_decode
    import lsag_pkg::*;
(
    input  logic [31:0] instr,
    output ls_fields_t  fields
);
    always_comb begin
        fields.reg_form  = instr[25];
        fields.add       = instr[23];
        fields.byte_acc  = instr[22];
        fields.load      = instr[20];
        fields.base_idx  = instr[19:16];
        fields.dest_idx  = instr[15:12];
        fields.imm       = instr[IMM_W-1:0];
        fields.shamt     = instr[11:7];
        fields.kind      = shift_kind_e'(instr[6:5]);
        fields.bad_shift = instr[25] & instr[4];
        unique case ({instr[24], instr[21]})
            2'b11:   fields.mode = MODE_PRE;
            2'b10:   fields.mode = MODE_OFFSET;
            default: fields.mode = MODE_POST;
        endcase
        fields.user_acc = ~instr[24] & instr[21];
    end
endmodule

// File: rtl/lsag_shift.sv
module lsag_shift
    import lsag_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0]       value,
    input  logic [SHAMT_W-1:0] amount,
    input  shift_kind_e        kind,
    input  logic               carry,
    output logic [W-1:0]       result
);
    always_comb begin
        unique case (kind)
            SH_LSL: result = value << amount;
            SH_LSR: result = (amount == '0) ? '0 : (value >> amount);
            SH_ASR: result = (amount == '0) ? {W{value[W-1]}}
                                            : W'($signed(value) >>> amount);
            SH_ROR: begin
                if (amount == '0)
                    result = {carry, value[W-1:1]};
                else
                    result = (value >> amount) | (value << (W - int'(amount)));
            end
            default: result = value;
        endcase
    end
endmodule

// File: rtl/lsag_unit.sv
module lsag_unit
    import lsag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid_in,
    input  logic [31:0]          instr_in,
    input  logic [XLEN-1:0]      rn_val,
    input  logic [XLEN-1:0]      rm_val,
    input  logic [XLEN-1:0]      pc_val,
    input  logic                 carry_in,
    output logic                 valid_out,
    output logic [XLEN-1:0]      addr_out,
    output logic [XLEN-1:0]      base_new,
    output logic                 base_wb,
    output logic [REG_IDX_W-1:0] wb_reg,
    output logic                 is_byte,
    output logic                 is_load,
    output logic                 force_user,
    output logic                 undef_out
);
    localparam logic [REG_IDX_W-1:0] PC_IDX = '1;

    typedef enum logic {ST_EMPTY, ST_HOLDING} out_state_e;
    out_state_e state_q, state_d;

    ls_fields_t      f;
    logic [XLEN-1:0] shifted, offset, base_eff, sum;
    logic [XLEN-1:0] addr_d;
    logic            wb_d;

    lsag_decode u_dec (.instr(instr_in), .fields(f));

    lsag_shift #(.W(XLEN)) u_shf (
        .value  (rm_val),
        .amount (f.shamt),
        .kind   (f.kind),
        .carry  (carry_in),
        .result (shifted)
    );

    always_comb begin
        base_eff = (f.base_idx == PC_IDX) ? pc_val + XLEN'(PC_AHEAD) : rn_val;
        offset   = f.reg_form ? shifted : XLEN'(f.imm);
        sum      = f.add ? base_eff + offset : base_eff - offset;
        unique case (f.mode)
            MODE_POST: begin addr_d = base_eff; wb_d = 1'b1; end
            MODE_PRE:  begin addr_d = sum;      wb_d = 1'b1; end
            default:   begin addr_d = sum;      wb_d = 1'b0; end
        endcase
        if (f.base_idx == PC_IDX || f.bad_shift || (f.load && f.dest_idx == f.base_idx))
            wb_d = 1'b0;
    end

    always_comb begin
        unique case (state_q)
            ST_EMPTY:   state_d = valid_in ? ST_HOLDING : ST_EMPTY;
            ST_HOLDING: state_d = valid_in ? ST_HOLDING : ST_EMPTY;
            default:    state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst || !valid_in) begin
            addr_out   <= '0;
            base_new   <= '0;
            base_wb    <= 1'b0;
            wb_reg     <= '0;
            is_byte    <= 1'b0;
            is_load    <= 1'b0;
            force_user <= 1'b0;
            undef_out  <= 1'b0;
        end else begin
            addr_out   <= addr_d;
            base_new   <= sum;
            base_wb    <= wb_d;
            wb_reg     <= f.base_idx;
            is_byte    <= f.byte_acc;
            is_load    <= f.load;
            force_user <= f.user_acc;
            undef_out  <= f.bad_shift;
        end
    end

    assign valid_out = (state_q == ST_HOLDING);
endmodule

// File: rtl/lsag_unit_chk.sv
module lsag_unit_chk
    import lsag_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [31:0]          instr_in,
    input logic [XLEN-1:0]      rn_val,
    input logic                 valid_out,
    input logic [XLEN-1:0]      addr_out,
    input logic [XLEN-1:0]      base_new,
    input logic                 base_wb,
    input logic [REG_IDX_W-1:0] wb_reg,
    input logic                 force_user,
    input logic                 undef_out,
    input logic                 is_load
);
    assert_post_addr_R3: assert property (@(posedge clk) disable iff (rst)
        valid_out && !$past(instr_in[24]) && $past(instr_in[19:16]) != 4'hF
        |-> addr_out == $past(rn_val));

    assert_offset_nowb_R5: assert property (@(posedge clk) disable iff (rst)
        valid_out && $past(instr_in[24]) && !$past(instr_in[21])
        |-> !base_wb && addr_out == base_new);

    assert_user_mode_R6: assert property (@(posedge clk) disable iff (rst)
        valid_out && force_user |-> !$past(instr_in[24]) && $past(instr_in[21]));

    assert_undef_nowb_R8: assert property (@(posedge clk) disable iff (rst)
        valid_out && undef_out |-> !base_wb);

    assert_pc_base_R9: assert property (@(posedge clk) disable iff (rst)
        valid_out && base_wb |-> wb_reg != 4'hF);

    assert_load_wins_R10: assert property (@(posedge clk) disable iff (rst)
        valid_out && is_load && $past(instr_in[15:12]) == $past(instr_in[19:16])
        |-> !base_wb);

    assert_reset_idle_R11: assert property (@(posedge clk)
        rst |=> !valid_out && !base_wb);
endmodule

bind lsag_unit lsag_unit_chk u_chk (
    .clk(clk), .rst(rst), .instr_in(instr_in), .rn_val(rn_val),
    .valid_out(valid_out), .addr_out(addr_out), .base_new(base_new),
    .base_wb(base_wb), .wb_reg(wb_reg), .force_user(force_user),
    .undef_out(undef_out), .is_load(is_load)
);

// File: tb/lsag_unit_test.sv
module lsag_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_in = 1'b0;
    logic [31:0] instr_in = '0;
    logic [31:0] rn_val = '0, rm_val = '0, pc_val = 32'h1000;
    logic        carry_in = 1'b0;
    logic        valid_out, base_wb, is_byte, is_load, force_user, undef_out;
    logic [31:0] addr_out, base_new;
    logic [3:0]  wb_reg;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lsag_unit uut (
        .clk(clk), .rst(rst), .valid_in(valid_in), .instr_in(instr_in),
        .rn_val(rn_val), .rm_val(rm_val), .pc_val(pc_val), .carry_in(carry_in),
        .valid_out(valid_out), .addr_out(addr_out), .base_new(base_new),
        .base_wb(base_wb), .wb_reg(wb_reg), .is_byte(is_byte), .is_load(is_load),
        .force_user(force_user), .undef_out(undef_out)
    );

    typedef struct packed {
        logic [7:0]  tag;
        logic        i, p, u, b, w, l;
        logic [3:0]  rn, rd;
        logic [11:0] low;
        logic [31:0] rnv, rmv;
        logic        c;
        logic [31:0] ea, en;
        logic        ewb, efu, eud;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        // R2 immediate add, R5 offset mode
        '{8'd2, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b1, 4'd1,4'd2, 12'h123, 32'h1000, 32'h0, 1'b0, 32'h1123, 32'h1123, 1'b0,1'b0,1'b0},
        // R2 immediate subtract, full 12 bits zero-extended
        '{8'd2, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 4'd1,4'd2, 12'hFFF, 32'h2000, 32'h0, 1'b0, 32'h1001, 32'h1001, 1'b0,1'b0,1'b0},
        // R4 pre-indexed with write-back
        '{8'd4, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 4'd3,4'd4, 12'h010, 32'h100, 32'h0, 1'b0, 32'h110, 32'h110, 1'b1,1'b0,1'b0},
        // R3 post-indexed add
        '{8'd3, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 4'd3,4'd4, 12'h008, 32'h200, 32'h0, 1'b0, 32'h200, 32'h208, 1'b1,1'b0,1'b0},
        // R3 post-indexed subtract
        '{8'd3, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 4'd5,4'd6, 12'h004, 32'h300, 32'h0, 1'b0, 32'h300, 32'h2FC, 1'b1,1'b0,1'b0},
        // R6 post-indexed with W: user access plus write-back
        '{8'd6, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b1, 4'd5,4'd6, 12'h020, 32'h400, 32'h0, 1'b0, 32'h400, 32'h420, 1'b1,1'b1,1'b0},
        // R7 LSL #2
        '{8'd7, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 4'd1,4'd2, 12'h103, 32'h1000, 32'h10, 1'b0, 32'h1040, 32'h1040, 1'b0,1'b0,1'b0},
        // R7 LSR #4
        '{8'd7, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 4'd1,4'd2, 12'h223, 32'h1000, 32'hF0, 1'b0, 32'h100F, 32'h100F, 1'b0,1'b0,1'b0},
        // R7 LSR #0 means 32
        '{8'd7, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 4'd1,4'd2, 12'h023, 32'h1000, 32'hFFFFFFFF, 1'b0, 32'h1000, 32'h1000, 1'b0,1'b0,1'b0},
        // R7 ASR #0 means 32
        '{8'd7, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 4'd1,4'd2, 12'h043, 32'h1000, 32'h80000000, 1'b0, 32'h0FFF, 32'h0FFF, 1'b0,1'b0,1'b0},
        // R7 ASR #4, subtract
        '{8'd7, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 4'd1,4'd2, 12'h243, 32'h1000, 32'h80000000, 1'b0, 32'h08001000, 32'h08001000, 1'b0,1'b0,1'b0},
        // R7 ROR #8
        '{8'd7, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 4'd1,4'd2, 12'h463, 32'h1000, 32'hAB, 1'b0, 32'hAB001000, 32'hAB001000, 1'b0,1'b0,1'b0},
        // R7 RRX with carry set
        '{8'd7, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 4'd1,4'd2, 12'h063, 32'h1000, 32'h3, 1'b1, 32'h80001001, 32'h80001001, 1'b0,1'b0,1'b0},
        // R7 RRX with carry clear
        '{8'd7, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 4'd1,4'd2, 12'h063, 32'h1000, 32'h3, 1'b0, 32'h1001, 32'h1001, 1'b0,1'b0,1'b0},
        // R7 register offset, post-indexed, adds
        '{8'd7, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 4'd1,4'd2, 12'h083, 32'h500, 32'h10, 1'b0, 32'h500, 32'h520, 1'b1,1'b0,1'b0},
        // R8 register-specified shift
        '{8'd8, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b1, 4'd1,4'd2, 12'h013, 32'h1000, 32'h0, 1'b0, 32'h1000, 32'h1000, 1'b0,1'b0,1'b1},
        // R9 base r15 reads pc+8, no write-back
        '{8'd9, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 4'd15,4'd2, 12'h004, 32'hDEAD0000, 32'h0, 1'b0, 32'h100C, 32'h100C, 1'b0,1'b0,1'b0},
        // R10 load into the base register
        '{8'd10, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 4'd4,4'd4, 12'h004, 32'h40, 32'h0, 1'b0, 32'h44, 32'h44, 1'b0,1'b0,1'b0},
        // R10 store from the base register keeps write-back
        '{8'd10, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 4'd4,4'd4, 12'h004, 32'h40, 32'h0, 1'b0, 32'h44, 32'h44, 1'b1,1'b0,1'b0},
        // R1 byte store
        '{8'd1, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 4'd1,4'd2, 12'h001, 32'h10, 32'h0, 1'b0, 32'h11, 32'h11, 1'b0,1'b0,1'b0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 outputs idle during reset
        check("R11", "valid_out in reset", {31'b0, valid_out}, 32'h0);
        check("R11", "addr_out in reset", addr_out, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            vec_t v;
            string rq;
            v = VECS[k];
            rq = $sformatf("R%0d", v.tag);
            instr_in = {4'hE, 2'b01, v.i, v.p, v.u, v.b, v.w, v.l, v.rn, v.rd, v.low};
            rn_val   = v.rnv;
            rm_val   = v.rmv;
            carry_in = v.c;
            valid_in = 1'b1;
            @(negedge clk);
            check(rq, $sformatf("vec%0d addr", k), addr_out, v.ea);
            check(rq, $sformatf("vec%0d base_new", k), base_new, v.en);
            check(rq, $sformatf("vec%0d flags wb/fu/ud", k),
                  {29'b0, base_wb, force_user, undef_out}, {29'b0, v.ewb, v.efu, v.eud});
            // R1 direction, size, valid, base index
            check("R1", $sformatf("vec%0d valid/byte/load/reg", k),
                  {25'b0, valid_out, is_byte, is_load, wb_reg},
                  {25'b0, 1'b1, v.b, v.l, v.rn});
        end

        // R1 no instruction offered: valid_out drops after one edge
        valid_in = 1'b0;
        @(negedge clk);
        check("R1", "valid_out idle", {31'b0, valid_out}, 32'h0);

        // R11 reset after activity clears the outputs
        instr_in = {4'hE, 2'b01, 6'b011011, 4'd3, 4'd4, 12'h010};
        rn_val   = 32'h100;
        valid_in = 1'b1;
        @(negedge clk);
        check("R4", "pre-index before reset", addr_out, 32'h110);
        rst = 1'b1;
        @(negedge clk);
        check("R11", "valid_out after reset", {31'b0, valid_out}, 32'h0);
        check("R11", "base_wb after reset", {31'b0, base_wb}, 32'h0);
        check("R11", "base_new after reset", base_new, 32'h0);
        rst = 1'b0;
        valid_in = 1'b0;
        @(negedge clk);
        summary();
    end
endmodule